// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Node

This block is the coherence controller of one node in a small shared-bus multiprocessor. It holds a direct-mapped, write-back cache with one data word per line. Each line is in one of three states: invalid, shared (clean, possibly held elsewhere) or exclusive (dirty, the only copy). Processor reads and writes that the line state allows are served locally. Any other access asks for the bus. Once granted, the node issues a read-miss, a write-miss or a writeback.

In every cycle where another node owns the bus, the controller looks the bus address up in its own tags. A foreign write-miss removes any local copy. A foreign read-miss turns a dirty copy into a shared one. In both cases the dirty owner drives its word onto the bus, and the requester takes that word in place of memory. A processor write to a shared line does not send a separate invalidate. It goes out as a write-miss, so one transaction removes the other copies and returns the current data. Several identical nodes sit on one bus next to an external arbiter and memory. The processor holds its request until `cpu_ready_o` is high.

Top module: `snoop_inv_ctrl`

## Requirements
- R1: After reset every line is invalid and `bus_req_o` is low. The first access to any address therefore goes to the bus.
- R2: A read to an invalid or different-tag line issues command 1 (read-miss) and fills the line as shared. A later read of the same address completes in the first cycle with no bus request.
- R3: A write to a line that is not valid with a matching tag issues command 2 (write-miss) and fills the line as exclusive. A write to an exclusive line with a matching tag completes in the first cycle with no bus traffic.
- R4: A write to a line held shared with a matching tag issues command 2 (write-miss), exactly like a write miss.
- R5: A foreign write-miss that matches a valid local line makes that line invalid. The next local access to that address goes to the bus.
- R6: When a foreign read-miss or write-miss matches a local exclusive line, the node raises `snp_supply_o` and drives the line's data on `snp_data_o` in that same bus cycle.
- R7: A foreign read-miss that matches a local exclusive line moves it to shared. A later local write to that address then issues a write-miss.
- R8: A miss that displaces an exclusive line with a different tag first issues command 3 (writeback), carrying the old address and data. The miss command follows in the next bus grant.
- R9: In any cycle where another node owns the bus, the snoop has the tag array and the processor is stalled (`cpu_ready_o` low). This holds even for a hit.
- R10: Every processor read returns the value most recently written to that address by any node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| cpu_ready_o | output | 1 | Access completes this cycle |
| bus_req_o | output | 1 | Request for the shared bus |
| bus_gnt_i | input | 1 | Bus granted to this node this cycle |
| bus_cmd_o | output | 2 | Command driven when granted: 1 read-miss, 2 write-miss, 3 writeback |
| bus_addr_o | output | ADDR_W | Address driven when granted |
| bus_wdata_o | output | DATA_W | Writeback data driven when granted |
| bus_valid_i | input | 1 | A transaction is on the bus this cycle |
| bus_cmd_i | input | 2 | Command on the bus |
| bus_addr_i | input | ADDR_W | Address on the bus |
| bus_rdata_i | input | DATA_W | Fill data on the bus (supplying owner or memory) |
| snp_supply_o | output | 1 | This node owns the snooped word dirty and supplies it |
| snp_data_o | output | DATA_W | Data supplied by this node |

## Verification
The hardest case to reach from the ports is the stall of R9. A processor hit on one node has to arrive in exactly the cycle in which another node's bus transaction goes out. The bench first makes one node the exclusive owner of a line. It then starts a read miss on the other node and, one cycle later, a write hit on the owner. The owner's hit must take two cycles instead of one. Dirty supply on both kinds of miss, the shared-to-write-miss path and the writeback-before-fill ordering are driven by scripted ping-pong sequences on one address. A scoreboard checks every read value against the last write.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {L_INV = 2'd0, L_SHD = 2'd1, L_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {C_NONE = 2'd0, C_RDMISS = 2'd1, C_WRMISS = 2'd2, C_WB = 2'd3} bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_dat_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_dat_o,
  input  logic              s_we_i,
  input  line_st_e          s_st_i,
  input  logic              p_we_i,
  input  line_st_e          p_st_i,
  input  logic [TAG_W-1:0]  p_tag_i,
  input  logic [DATA_W-1:0] p_dat_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_arr  [LINES];
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= L_INV;
        tag_q <= '0;
        dat_q <= '0;
      end else if (s_we_i && b_idx_i == IDX_W'(i)) begin
        st_q <= s_st_i;  // snoop wins
      end else if (p_we_i && a_idx_i == IDX_W'(i)) begin
        st_q  <= p_st_i;
        tag_q <= p_tag_i;
        dat_q <= p_dat_i;
      end
    end
    assign st_arr[i]  = st_q;
    assign tag_arr[i] = tag_q;
    assign dat_arr[i] = dat_q;
  end

  assign a_st_o  = st_arr[a_idx_i];
  assign a_tag_o = tag_arr[a_idx_i];
  assign a_dat_o = dat_arr[a_idx_i];
  assign b_st_o  = st_arr[b_idx_i];
  assign b_tag_o = tag_arr[b_idx_i];
  assign b_dat_o = dat_arr[b_idx_i];

  // R5/R9: snoop and processor never update the array in the same cycle
  a_r5_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_we_i && p_we_i));
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              bus_valid_i,
  input  logic              bus_gnt_i,
  input  logic [1:0]        bus_cmd_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_dat_i,
  output logic              foreign_o,
  output logic              upd_o,
  output line_st_e          upd_st_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] supply_dat_o
);
  logic hit, is_rd, is_wr;

  assign foreign_o    = bus_valid_i && !bus_gnt_i;
  assign hit          = foreign_o && line_st_i != L_INV && line_tag_i == bus_tag_i;
  assign is_rd        = bus_cmd_i == C_RDMISS;
  assign is_wr        = bus_cmd_i == C_WRMISS;
  assign supply_o     = hit && line_st_i == L_EXC && (is_rd || is_wr);
  assign supply_dat_o = line_dat_i;

  always_comb begin
    upd_o    = 1'b0;
    upd_st_o = line_st_i;
    if (hit && is_wr) begin
      upd_o    = 1'b1;
      upd_st_o = L_INV;
    end else if (hit && is_rd && line_st_i == L_EXC) begin
      upd_o    = 1'b1;
      upd_st_o = L_SHD;
    end
  end
endmodule

// File: rtl/snoop_inv_ctrl.sv
module snoop_inv_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_MISS} fsm_e;

  fsm_e              fsm_q, fsm_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  req_tag;
  line_st_e          a_st, b_st, s_st, p_st;
  logic [TAG_W-1:0]  a_tag, b_tag, p_tag;
  logic [DATA_W-1:0] a_dat, b_dat, p_dat;
  logic              s_we, p_we, foreign, tag_eq, hit, miss, victim_dirty;

  assign a_idx   = (fsm_q == S_IDLE) ? cpu_addr_i[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign req_tag = (fsm_q == S_IDLE) ? cpu_addr_i[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
  assign tag_eq  = a_tag == req_tag;
  assign hit     = tag_eq && (cpu_we_i ? (a_st == L_EXC) : (a_st != L_INV));
  assign victim_dirty = a_st == L_EXC;

  assign cpu_ready_o = fsm_q == S_IDLE && cpu_req_i && !foreign && hit;
  assign miss        = fsm_q == S_IDLE && cpu_req_i && !foreign && !hit;
  assign cpu_rdata_o = a_dat;

  assign bus_req_o   = (fsm_q == S_WB && victim_dirty) || fsm_q == S_MISS;
  assign bus_cmd_o   = (fsm_q == S_WB) ? C_WB : (we_q ? C_WRMISS : C_RDMISS);
  assign bus_addr_o  = (fsm_q == S_WB) ? {a_tag, addr_q[IDX_W-1:0]} : addr_q;
  assign bus_wdata_o = a_dat;

  always_comb begin
    fsm_d = fsm_q;
    p_we  = 1'b0;
    p_st  = a_st;
    p_tag = a_tag;
    p_dat = a_dat;
    unique case (fsm_q)
      S_IDLE: begin
        if (cpu_ready_o && cpu_we_i) begin
          p_we  = 1'b1;
          p_st  = L_EXC;
          p_dat = cpu_wdata_i;
        end else if (miss) begin
          fsm_d = (victim_dirty && !tag_eq) ? S_WB : S_MISS;
        end
      end
      S_WB: begin
        if (!victim_dirty) begin
          fsm_d = S_MISS;  // lost ownership to a snoop, nothing to write back
        end else if (bus_gnt_i) begin
          p_we  = 1'b1;
          p_st  = L_INV;
          fsm_d = S_MISS;
        end
      end
      S_MISS: begin
        if (bus_gnt_i) begin
          p_we  = 1'b1;
          p_st  = we_q ? L_EXC : L_SHD;
          p_tag = addr_q[ADDR_W-1:IDX_W];
          p_dat = we_q ? wdata_q : bus_rdata_i;
          fsm_d = S_IDLE;
        end
      end
      default: fsm_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= S_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (miss) begin
        we_q    <= cpu_we_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
      end
    end
  end

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_idx_i (a_idx),
    .a_st_o  (a_st),
    .a_tag_o (a_tag),
    .a_dat_o (a_dat),
    .b_idx_i (bus_addr_i[IDX_W-1:0]),
    .b_st_o  (b_st),
    .b_tag_o (b_tag),
    .b_dat_o (b_dat),
    .s_we_i  (s_we),
    .s_st_i  (s_st),
    .p_we_i  (p_we),
    .p_st_i  (p_st),
    .p_tag_i (p_tag),
    .p_dat_i (p_dat)
  );

  coh_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .bus_valid_i  (bus_valid_i),
    .bus_gnt_i    (bus_gnt_i),
    .bus_cmd_i    (bus_cmd_i),
    .bus_tag_i    (bus_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i    (b_st),
    .line_tag_i   (b_tag),
    .line_dat_i   (b_dat),
    .foreign_o    (foreign),
    .upd_o        (s_we),
    .upd_st_o     (s_st),
    .supply_o     (snp_supply_o),
    .supply_dat_o (snp_data_o)
  );

  a_r9_snoop_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_gnt_i) |-> !cpu_ready_o);

  a_r8_wb_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == C_WB) |=> (bus_req_o && bus_cmd_o != C_WB));

  a_r3_ready_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !bus_req_o);

  a_r6_supply_drops_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |=> !snp_supply_o);
endmodule

// File: tb/tb_snoop_inv_ctrl.sv
module tb_snoop_inv_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int N  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req [N];
  logic          we  [N];
  logic [AW-1:0] addr [N];
  logic [DW-1:0] wdata [N];
  logic [DW-1:0] rdata [N];
  logic          rdy [N];
  logic          breq [N];
  logic          gnt [N];
  logic [1:0]    bcmd_o [N];
  logic [AW-1:0] baddr_o [N];
  logic [DW-1:0] bwd_o [N];
  logic          sup [N];
  logic [DW-1:0] supd [N];

  logic          bvalid, prio;
  logic [1:0]    bcmd;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bwd, brdata;
  logic [DW-1:0] mem [1 << AW];

  for (genvar i = 0; i < N; i++) begin : g_node
    snoop_inv_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) dut (
      .clk_i(clk), .rst_ni(rst_n),
      .cpu_req_i(req[i]), .cpu_we_i(we[i]), .cpu_addr_i(addr[i]), .cpu_wdata_i(wdata[i]),
      .cpu_rdata_o(rdata[i]), .cpu_ready_o(rdy[i]),
      .bus_req_o(breq[i]), .bus_gnt_i(gnt[i]), .bus_cmd_o(bcmd_o[i]),
      .bus_addr_o(baddr_o[i]), .bus_wdata_o(bwd_o[i]),
      .bus_valid_i(bvalid), .bus_cmd_i(bcmd), .bus_addr_i(baddr), .bus_rdata_i(brdata),
      .snp_supply_o(sup[i]), .snp_data_o(supd[i]));
  end

  // arbiter, bus mux, memory
  assign gnt[0] = breq[0] && (!breq[1] || !prio);
  assign gnt[1] = breq[1] && (!breq[0] || prio);
  assign bvalid = gnt[0] || gnt[1];
  assign bcmd   = gnt[0] ? bcmd_o[0]  : (gnt[1] ? bcmd_o[1]  : 2'd0);
  assign baddr  = gnt[0] ? baddr_o[0] : baddr_o[1];
  assign bwd    = gnt[0] ? bwd_o[0]   : bwd_o[1];
  assign brdata = sup[0] ? supd[0] : (sup[1] ? supd[1] : mem[baddr]);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio <= 1'b0;
      for (int a = 0; a < (1 << AW); a++) mem[a] <= 16'h1000 + 16'(a);
    end else begin
      if (bvalid) prio <= gnt[0];
      if (bvalid && bcmd == 2'd3) mem[baddr] <= bwd;
      else if (sup[0] || sup[1]) mem[baddr] <= brdata;
    end
  end

  int checks = 0, errors = 0;
  int n_cmd [4];
  int n_sup = 0;
  logic [AW-1:0] wb_a;
  logic [DW-1:0] wb_d;
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] exp_q [$];
  int            exp_n [$];

  initial for (int k = 0; k < 4; k++) n_cmd[k] = 0;
  initial for (int a = 0; a < (1 << AW); a++) model[a] = 16'h1000 + 16'(a);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n && bvalid) begin
      n_cmd[bcmd]++;
      if (bcmd == 2'd3) begin wb_a = baddr; wb_d = bwd; end
      if (sup[0] || sup[1]) n_sup++;
    end
    for (int i = 0; i < N; i++) begin
      if (rst_n && req[i] && !we[i] && rdy[i]) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected read", int'(rdata[i]), 0);
        end else begin
          logic [DW-1:0] e;
          int en;
          e  = exp_q.pop_front();
          en = exp_n.pop_front();
          chk(rdata[i] == e && en == i, "R10 read value", int'(rdata[i]), int'(e));
        end
      end
    end
  end

  task automatic do_op(input int n, input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int cyc);
    if (w) model[a] = d;
    else begin exp_q.push_back(model[a]); exp_n.push_back(n); end
    req[n] = 1'b1; we[n] = w; addr[n] = a; wdata[n] = d;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rdy[n]) break;
    end
    @(posedge clk); #1;
    req[n] = 1'b0;
  endtask

  int b_rd, b_wr, b_wb, b_sup;
  task automatic snap();
    b_rd = n_cmd[1]; b_wr = n_cmd[2]; b_wb = n_cmd[3]; b_sup = n_sup;
  endtask

  initial begin
    int c, c2;
    for (int i = 0; i < N; i++) begin req[i] = 0; we[i] = 0; addr[i] = '0; wdata[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!breq[0] && !breq[1], "R1 no bus request after reset", int'(breq[0]), 0);
    chk(!rdy[0] && !rdy[1], "R1 not ready after reset", int'(rdy[0]), 0);
    @(posedge clk); #1;

    snap(); do_op(0, 0, 8'h10, 0, c);
    chk(c == 3, "R1 first read misses", c, 3);
    chk(n_cmd[1] - b_rd == 1, "R2 read-miss issued", n_cmd[1] - b_rd, 1);

    snap(); do_op(0, 0, 8'h10, 0, c);
    chk(c == 1 && n_cmd[1] + n_cmd[2] + n_cmd[3] == b_rd + b_wr + b_wb, "R2 read hit local", c, 1);

    snap(); do_op(1, 0, 8'h10, 0, c);
    chk(n_cmd[1] - b_rd == 1 && n_sup == b_sup, "R2 clean read-miss from memory", n_sup - b_sup, 0);

    snap(); do_op(1, 1, 8'h10, 16'hAAAA, c);
    chk(n_cmd[2] - b_wr == 1, "R4 shared write issues write-miss", n_cmd[2] - b_wr, 1);

    snap(); do_op(0, 0, 8'h10, 0, c);
    chk(n_cmd[1] - b_rd == 1, "R5 invalidated copy misses", n_cmd[1] - b_rd, 1);
    chk(n_sup - b_sup == 1, "R6 owner supplies on read-miss", n_sup - b_sup, 1);

    snap(); do_op(1, 1, 8'h10, 16'hBBBB, c);
    chk(n_cmd[2] - b_wr == 1, "R7 downgraded owner write-miss", n_cmd[2] - b_wr, 1);

    snap(); do_op(0, 1, 8'h10, 16'hCCCC, c);
    chk(n_cmd[2] - b_wr == 1 && n_sup - b_sup == 1, "R6 owner supplies on write-miss", n_sup - b_sup, 1);

    snap(); do_op(0, 1, 8'h10, 16'hDDDD, c);
    chk(c == 1 && n_cmd[2] == b_wr && n_cmd[1] == b_rd, "R3 write hit local", c, 1);

    snap(); do_op(0, 1, 8'h20, 16'h1111, c);
    chk(n_cmd[3] - b_wb == 1 && n_cmd[2] - b_wr == 1 && c == 4, "R8 writeback then miss", c, 4);
    chk(wb_a == 8'h10 && wb_d == 16'hDDDD, "R8 writeback content", int'(wb_d), 16'hDDDD);

    snap(); do_op(1, 0, 8'h10, 0, c);
    chk(n_sup == b_sup && n_cmd[1] - b_rd == 1, "R8 memory holds written-back value", n_sup - b_sup, 0);

    snap(); do_op(0, 1, 8'h33, 16'h0005, c);
    chk(n_cmd[2] - b_wr == 1 && c == 3, "R3 write miss fills exclusive", c, 3);

    do_op(1, 1, 8'h02, 16'h7777, c);
    snap();
    fork
      do_op(0, 0, 8'h45, 0, c);
      begin @(posedge clk); #1; do_op(1, 1, 8'h02, 16'h8888, c2); end
    join
    chk(c2 == 2, "R9 hit stalled by foreign transaction", c2, 2);
    chk(n_cmd[1] - b_rd == 1, "R9 foreign read-miss went out", n_cmd[1] - b_rd, 1);

    snap(); do_op(0, 0, 8'h02, 0, c);
    chk(n_sup - b_sup == 1, "R6 supply of stalled write", n_sup - b_sup, 1);
    do_op(1, 0, 8'h02, 0, c);
    chk(c == 1, "R7 owner kept shared copy", c, 1);

    do_op(0, 0, 8'h20, 0, c);
    chk(c == 1, "R3 exclusive line read hit", c, 1);
    snap(); do_op(1, 0, 8'h20, 0, c);
    chk(n_sup - b_sup == 1, "R10 dirty value supplied", n_sup - b_sup, 1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule